// File: doc/BRIEF.md
# Dual-Source Converter Clock Divider

This block produces the clock enable for an analog-to-digital converter from one of two upstream enable streams: the divided peripheral-bus enable or the faster high-speed-bus enable. A single 4-bit configuration code picks both the stream and the division ratio. The peripheral stream can be divided by an even ratio from 2 to 16. The high-speed stream can be divided by 5, 6, 10 or 20, so its ratios need not be powers of two.

Each enable pulse on the selected stream advances a counter. When the counter reaches the ratio, the block emits a one-cycle converter enable. Changing the code restarts the count, so the first enable under a new setting comes a full new period later. Software reports the frequency of the selected source in kHz. The block compares the resulting converter rate against a 40 MHz ceiling and raises a flag when the rate is too high.

Top module: `conv_clk_div`

## Requirements
- R1: During reset and after it is released, `conv_en` and `rate_err` are 0 and the pulse count is cleared.
- R2: When `div_code[3]` is 0, only `pbus_en` pulses are counted. `hbus_en` has no effect on `conv_en`.
- R3: When `div_code[3]` is 1, only `hbus_en` pulses are counted. `pbus_en` has no effect on `conv_en`.
- R4: Codes 0, 1, 2, 3, 4 and 5 give peripheral ratios of 2, 4, 6, 8, 12 and 16 respectively.
- R5: Codes 8, 9, 10 and 11 give high-speed ratios of 5, 6, 10 and 20 respectively.
- R6: Codes 6 and 7 fall back to ratio 16. Codes 12 to 15 fall back to ratio 20.
- R7: `conv_en` is a single-cycle pulse. It is asserted in the cycle after the ratio-th counted source pulse, and the count then restarts at zero.
- R8: In any cycle where `div_code` differs from its value in the previous cycle, the count clears and a source pulse in that cycle is not counted. The next `conv_en` follows after a full ratio of later pulses.
- R9: One cycle after the inputs are applied, `rate_err` equals (`src_freq_khz` > 40000 × ratio), using the ratio of the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pbus_en | input | 1 | Peripheral-bus enable pulse stream |
| hbus_en | input | 1 | High-speed-bus enable pulse stream |
| div_code | input | 4 | Bit 3 selects the source (0 = peripheral, 1 = high-speed); bits 2:0 select the ratio |
| src_freq_khz | input | 20 | Frequency of the selected source in kHz |
| conv_en | output | 1 | Converter clock enable, one cycle wide |
| rate_err | output | 1 | Set when the converter rate would exceed 40 MHz |

## Verification
Two events can land in the same cycle: a code change and the source pulse that would complete a period. In that case the change must win, with no enable and a cleared count. The bench provokes this in two ways. It switches the code in exactly the cycle of the last pulse of a period. It also applies random code changes while the selected stream pulses every cycle. A behavioural reference model, compared on every clock, judges whether the enable was suppressed and whether the following enable arrives one full new period later.

// File: rtl/conv_div_pkg.sv
package conv_div_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 5;

  typedef enum logic {SRC_PBUS = 1'b0, SRC_HBUS = 1'b1} src_e;

  typedef struct packed {
    src_e               src;
    logic [RATIO_W-1:0] ratio;
  } div_cfg_t;

  function automatic div_cfg_t decode_code(input logic [CODE_W-1:0] code);
    div_cfg_t cfg;
    cfg.src = src_e'(code[CODE_W-1]);
    if (code[CODE_W-1] == 1'b0) begin
      case (code[2:0])
        3'd0:    cfg.ratio = RATIO_W'(2);
        3'd1:    cfg.ratio = RATIO_W'(4);
        3'd2:    cfg.ratio = RATIO_W'(6);
        3'd3:    cfg.ratio = RATIO_W'(8);
        3'd4:    cfg.ratio = RATIO_W'(12);
        default: cfg.ratio = RATIO_W'(16);
      endcase
    end else begin
      case (code[2:0])
        3'd0:    cfg.ratio = RATIO_W'(5);
        3'd1:    cfg.ratio = RATIO_W'(6);
        3'd2:    cfg.ratio = RATIO_W'(10);
        default: cfg.ratio = RATIO_W'(20);
      endcase
    end
    return cfg;
  endfunction
endpackage

// File: rtl/conv_src_select.sv
module conv_src_select
  import conv_div_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  input  logic               pbus_en,
  input  logic               hbus_en,
  output logic [RATIO_W-1:0] ratio,
  output logic               src_pulse
);
  div_cfg_t cfg;

  always_comb begin
    cfg       = decode_code(code);
    ratio     = cfg.ratio;
    src_pulse = (cfg.src == SRC_HBUS) ? hbus_en : pbus_en;
  end
endmodule

// File: rtl/conv_pulse_counter.sv
module conv_pulse_counter #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse,
  input  logic               clear,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               tick_q, tick_d;
  logic [RATIO_W-1:0] last;

  always_comb begin
    last   = ratio - RATIO_W'(1);
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (pulse) begin
      if (cnt_q >= last) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + RATIO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R8
  change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (cnt_q == '0));

  // R7
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt_q < ratio));

  // R7
  tick_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(pulse));
endmodule

// File: rtl/conv_rate_check.sv
module conv_rate_check #(
  parameter int FREQ_W    = 20,
  parameter int RATIO_W   = 5,
  parameter int LIMIT_KHZ = 40000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FREQ_W-1:0]  freq_khz,
  input  logic [RATIO_W-1:0] ratio,
  output logic               err
);
  localparam int PROD_W = FREQ_W + RATIO_W + 1;

  logic [PROD_W-1:0] ceiling;
  logic              err_d, err_q;

  always_comb begin
    ceiling = PROD_W'(LIMIT_KHZ) * PROD_W'(ratio);
    err_d   = PROD_W'(freq_khz) > ceiling;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  // R9
  zero_freq_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freq_khz) == '0) |-> !err_q);
endmodule

// File: rtl/conv_clk_div.sv
module conv_clk_div
  import conv_div_pkg::*;
#(
  parameter int FREQ_W    = 20,
  parameter int LIMIT_KHZ = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pbus_en,
  input  logic              hbus_en,
  input  logic [3:0]        div_code,
  input  logic [FREQ_W-1:0] src_freq_khz,
  output logic              conv_en,
  output logic              rate_err
);
  logic               rst_meta, rst_sync_n;
  logic [CODE_W-1:0]  code_q;
  logic               code_chg;
  logic [RATIO_W-1:0] ratio;
  logic               src_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) code_q <= '0;
    else             code_q <= div_code;
  end

  assign code_chg = (div_code != code_q);

  conv_src_select u_sel (
    .code      (div_code),
    .pbus_en   (pbus_en),
    .hbus_en   (hbus_en),
    .ratio     (ratio),
    .src_pulse (src_pulse)
  );

  conv_pulse_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pulse (src_pulse),
    .clear (code_chg),
    .ratio (ratio),
    .tick  (conv_en)
  );

  conv_rate_check #(.FREQ_W(FREQ_W), .RATIO_W(RATIO_W), .LIMIT_KHZ(LIMIT_KHZ)) u_rate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .freq_khz (src_freq_khz),
    .ratio    (ratio),
    .err      (rate_err)
  );

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_en |=> !conv_en);

  // R8
  no_en_after_change_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_en |-> !$past(code_chg));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!conv_en && !rate_err));
endmodule

// File: tb/conv_clk_div_test.sv
module conv_clk_div_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pbus_en, hbus_en;
  logic [3:0]  div_code;
  logic [19:0] src_freq_khz;
  logic        conv_en, rate_err;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";

  int  m_cnt = 0;
  int  m_prev = 0;
  bit  exp_en = 1'b0;
  bit  exp_err = 1'b0;

  always #2 clk = ~clk;

  conv_clk_div uut (
    .clk(clk), .rst_n(rst_n), .pbus_en(pbus_en), .hbus_en(hbus_en),
    .div_code(div_code), .src_freq_khz(src_freq_khz),
    .conv_en(conv_en), .rate_err(rate_err)
  );

  function automatic int ref_ratio(input int c);
    int per[6] = '{2, 4, 6, 8, 12, 16};
    int fast[4] = '{5, 6, 10, 20};
    int idx = c % 8;
    if (c < 8) return (idx > 5) ? 16 : per[idx];
    return (idx > 3) ? 20 : fast[idx];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit p, input bit h, input int c, input int f);
    int r;
    bit pl;
    @(negedge clk);
    check(cur_req, "conv_en", int'(conv_en), int'(exp_en));
    check((cur_req == "R1") ? "R1" : "R9", "rate_err", int'(rate_err), int'(exp_err));
    pbus_en = p;
    hbus_en = h;
    div_code = 4'(c);
    src_freq_khz = 20'(f);
    r  = ref_ratio(c);
    pl = (c >= 8) ? h : p;
    exp_en = 1'b0;
    if (c != m_prev) begin
      m_cnt = 0;
    end else if (pl) begin
      m_cnt++;
      if (m_cnt == r) begin
        m_cnt  = 0;
        exp_en = 1'b1;
      end
    end
    m_prev  = c;
    exp_err = (f > 40000 * r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    rst_n = 1'b0; pbus_en = 0; hbus_en = 0; div_code = 0; src_freq_khz = 0;
    cur_req = "R1";
    repeat (3) step(0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0);

    // R2: hbus pulses ignored with peripheral source
    cur_req = "R2";
    repeat (30) step(0, 1, 4, 100000);
    repeat (40) step(1, 1'($urandom_range(0, 1)), 4, 100000);

    // R3: pbus pulses ignored with high-speed source
    cur_req = "R3";
    repeat (30) step(1, 0, 9, 200000);
    repeat (40) step(1'($urandom_range(0, 1)), 1, 9, 200000);

    // R4: peripheral ratios
    cur_req = "R4";
    for (int c = 0; c < 6; c++)
      repeat (40) step(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), c,
                       int'($urandom_range(0, 1000000)));

    // R5: high-speed ratios
    cur_req = "R5";
    for (int c = 8; c < 12; c++)
      repeat (50) step(1'($urandom_range(0, 1)), 1, c, int'($urandom_range(0, 1000000)));

    // R6: unused codes fall back
    cur_req = "R6";
    for (int c = 6; c < 16; c++) begin
      if (c >= 8 && c < 12) continue;
      repeat (50) step(1, 1, c, 300000);
    end

    // R7: sparse pulses, count conv_en pulses over a window
    cur_req = "R7";
    pulses = 0;
    repeat (2) step(0, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      step(1, 0, 1, 0);
      step(0, 0, 1, 0);
      pulses += int'(conv_en);
    end
    check("R7", "enable count for 40 pulses at ratio 4", pulses, 10);
    repeat (100) step(($urandom_range(0, 3) == 0), 0, 1, 0);

    // R8: change in the same cycle as the completing pulse
    cur_req = "R8";
    repeat (2) step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 2, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 2, 0);
    for (int k = 0; k < 40; k++) begin
      int c = int'($urandom_range(0, 15));
      repeat (int'($urandom_range(1, 20))) step(1, 1, c, int'($urandom_range(0, 1000000)));
    end

    // R9: rate flag boundaries
    cur_req = "R9";
    step(1, 1, 0, 80000);
    step(1, 1, 0, 80001);
    step(1, 1, 11, 800000);
    step(1, 1, 11, 800001);
    step(1, 1, 5, 640001);
    step(1, 1, 8, 200000);
    step(1, 1, 8, 200001);
    step(1, 1, 8, 0);
    step(0, 0, 8, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule